// File: doc/BRIEF.md
# Token-Chained Readout Slave

This block is the per-module end of a shared readout bus on which several data sources answer one block-transfer cycle in turn. Event words are pushed into a local FIFO by the module's own front end. A system acceptance pulse (`val_i`) opens a readout cycle. At that moment the slave records how many words it holds, and it pulls the shared active-low busy line for as long as it still owes those words.

Ownership of the bus moves down a daisy chain. A slave waits for its upstream neighbour's token. While it holds the token it answers each data strobe from the bus master with a four-phase strobe/acknowledge exchange, one word per exchange. It drives the data bus for at least one clock before it raises the acknowledge. When the recorded words are gone it releases the busy line and raises its token output into the next module. A slave with nothing to send forwards the token at once. Words that arrive after the acceptance pulse stay in the FIFO for the next event.

Top module: `ro_slave`

## Requirements
- R1: After reset `token_o`, `ack_o` and `data_oe_o` are 0, `busy_no` is 1 (line released) and `full_o` is 0.
- R2: When `val_i` is high at a clock edge while the slave is idle or has passed its token, `busy_no` reads 0 and `token_o` reads 0 from that edge on.
- R3: Before `token_i` has been seen high after the acceptance, a strobe on `ds_i` is ignored: `ack_o` and `data_oe_o` stay 0.
- R4: Once the slave owns the bus, a rising `ds_i` makes `data_oe_o` go to 1 with the word on `data_o`. `ack_o` rises no earlier than the second clock edge after `ds_i` is first sampled high, with `data_o` unchanged since the edge before. `ack_o` stays high while `ds_i` stays high and falls at the first edge that samples `ds_i` low.
- R5: The words are delivered in the order they were written, one per strobe/acknowledge exchange. The number delivered equals the FIFO occupancy seen at the accepting edge.
- R6: At the edge that completes the last exchange, `busy_no` returns to 1 and `token_o` goes to 1.
- R7: A slave that holds no words when it is accepted raises `token_o` at the first edge that samples `token_i` high, and never raises `ack_o`.
- R8: A word written at the accepting edge or later is not sent in that cycle. It is sent first in the next cycle.
- R9: A `val_i` pulse while the slave still owes words is ignored: the remaining transfer is unchanged.
- R10: `token_o` stays 1 until the next accepted `val_i`, and goes to 0 at that edge.
- R11: `full_o` is 1 when the FIFO holds `DEPTH` words. A write while full is dropped and leaves the stored words unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| val_i | input | 1 | Acceptance pulse that opens a readout cycle |
| token_i | input | 1 | Token from the upstream module |
| token_o | output | 1 | Token to the downstream module |
| ds_i | input | 1 | Data strobe from the bus master, active high |
| ack_o | output | 1 | Data acknowledge, active high |
| data_o | output | 32 | Readout data |
| data_oe_o | output | 1 | Enable for the data bus driver |
| busy_no | output | 1 | Busy pull-down, 0 means pulling the shared line low |
| wr_en_i | input | 1 | FIFO write enable |
| wr_data_i | input | 32 | FIFO write data |
| full_o | output | 1 | FIFO full |

## Verification
The hardest situation to reach is a FIFO that keeps filling while the transfer is under way. The bench has to show that the word count is frozen at the acceptance edge. To do this it writes extra words right after `val_i`, reads only the recorded words, and checks that the token rises before the late words appear. It then opens a second cycle and expects the late words first. A second stimulus strobes before handing over the token and pulses `val_i` in the middle of a transfer. This shows that neither event disturbs the exchange that follows.

// File: rtl/ro_pkg.sv
package ro_pkg;
  localparam int unsigned WORD_W = 32;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_TOK,
    ST_ARMED,
    ST_SETUP,
    ST_ACK,
    ST_PASS
  } ro_state_e;
endpackage

// File: rtl/ro_fifo.sv
module ro_fifo #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] head_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             full_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wptr_q, rptr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             push, pop;

  assign full_o = (cnt_q == CNT_W'(DEPTH));
  assign push   = wr_en_i && !full_o;
  assign pop    = pop_i && (cnt_q != '0);
  assign head_o = mem_q[rptr_q];
  assign cnt_o  = cnt_q;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (push) mem_q[wptr_q] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push) wptr_q <= nxt(wptr_q);
      if (pop)  rptr_q <= nxt(rptr_q);
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/ro_seq.sv
module ro_seq
  import ro_pkg::*;
#(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             val_i,
  input  logic             token_i,
  input  logic             ds_i,
  input  logic [CNT_W-1:0] fifo_cnt_i,
  input  logic [WIDTH-1:0] head_i,
  output logic             pop_o,
  output logic             token_o,
  output logic             ack_o,
  output logic [WIDTH-1:0] data_o,
  output logic             data_oe_o,
  output logic             busy_no
);
  ro_state_e        state_q, state_d;
  logic [CNT_W-1:0] owed_q;
  logic [WIDTH-1:0] data_q;
  logic             accept, last;

  assign accept = val_i && (state_q == ST_IDLE || state_q == ST_PASS);
  assign last   = (owed_q == CNT_W'(1));
  assign pop_o  = (state_q == ST_ACK) && !ds_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE, ST_PASS: if (val_i) state_d = ST_WAIT_TOK;
      ST_WAIT_TOK:      if (token_i) state_d = (owed_q == '0) ? ST_PASS : ST_ARMED;
      ST_ARMED:         if (ds_i) state_d = ST_SETUP;
      ST_SETUP:         state_d = ST_ACK;
      ST_ACK:           if (!ds_i) state_d = last ? ST_PASS : ST_ARMED;
      default:          state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      owed_q  <= '0;
      data_q  <= '0;
    end else begin
      state_q <= state_d;
      // snapshot excludes a write landing on the accepting edge
      if (accept)      owed_q <= fifo_cnt_i;
      else if (pop_o)  owed_q <= owed_q - 1'b1;
      if (state_q == ST_ARMED && ds_i) data_q <= head_i;
    end
  end

  assign token_o   = (state_q == ST_PASS);
  assign ack_o     = (state_q == ST_ACK);
  assign data_oe_o = (state_q == ST_SETUP) || (state_q == ST_ACK);
  assign data_o    = data_q;
  assign busy_no   = (state_q == ST_IDLE) || (state_q == ST_PASS);
endmodule

// File: rtl/ro_slave.sv
module ro_slave
  import ro_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              val_i,
  input  logic              token_i,
  output logic              token_o,
  input  logic              ds_i,
  output logic              ack_o,
  output logic [WORD_W-1:0] data_o,
  output logic              data_oe_o,
  output logic              busy_no,
  input  logic              wr_en_i,
  input  logic [WORD_W-1:0] wr_data_i,
  output logic              full_o
);
  logic [WORD_W-1:0] head;
  logic [CNT_W-1:0]  cnt;
  logic              pop;

  ro_fifo #(.WIDTH(WORD_W), .DEPTH(DEPTH)) u_fifo (
    .clk_i, .rst_ni, .wr_en_i, .wr_data_i,
    .pop_i(pop), .head_o(head), .cnt_o(cnt), .full_o
  );

  ro_seq #(.WIDTH(WORD_W), .CNT_W(CNT_W)) u_seq (
    .clk_i, .rst_ni, .val_i, .token_i, .ds_i,
    .fifo_cnt_i(cnt), .head_i(head), .pop_o(pop),
    .token_o, .ack_o, .data_o, .data_oe_o, .busy_no
  );
endmodule

// File: rtl/ro_slave_chk.sv
module ro_slave_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        val_i,
  input logic        ds_i,
  input logic        token_o,
  input logic        ack_o,
  input logic [31:0] data_o,
  input logic        data_oe_o,
  input logic        busy_no
);
  AST_ACK_OWNER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> (data_oe_o && !busy_no && !token_o)); // R3

  AST_ACK_SETUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_o) |-> ($past(data_oe_o) && $stable(data_o))); // R4

  AST_ACK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && ds_i) |=> ack_o); // R4

  AST_ACK_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && !ds_i) |=> !ack_o); // R4

  AST_TOKEN_FREE_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    token_o |-> (busy_no && !data_oe_o)); // R6

  AST_TOKEN_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (token_o && val_i) |=> (!token_o && !busy_no)); // R10

  AST_TOKEN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (token_o && !val_i) |=> token_o); // R10
endmodule

bind ro_slave ro_slave_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .val_i(val_i), .ds_i(ds_i),
  .token_o(token_o), .ack_o(ack_o), .data_o(data_o),
  .data_oe_o(data_oe_o), .busy_no(busy_no)
);

// File: tb/tb_ro_slave.sv
module tb_ro_slave;
  localparam int D = 8;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic val_i = 0, token_i = 0, ds_i = 0, wr_en_i = 0;
  logic [31:0] wr_data_i = '0;
  logic token_o, ack_o, data_oe_o, busy_no, full_o;
  logic [31:0] data_o;
  int total = 0, bad = 0;

  always #2 clk_i = ~clk_i;

  ro_slave #(.DEPTH(D)) dut (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] v);
    wr_en_i = 1; wr_data_i = v;
    @(negedge clk_i); wr_en_i = 0;
  endtask

  task automatic pulse_val();
    val_i = 1; @(negedge clk_i); val_i = 0;
  endtask

  task automatic read_word(input logic [31:0] exp, input string req);
    int n = 0;
    ds_i = 1;
    do begin @(negedge clk_i); n++; end while (!ack_o && n < 20);
    chk(ack_o && data_oe_o, req, {30'd0, ack_o, data_oe_o}, 32'd3);
    chk(data_o == exp, req, data_o, exp);
    chk(n >= 2, "R4 setup", n, 2);
    ds_i = 0; @(negedge clk_i);
    chk(!ack_o, "R4 release", ack_o, 0);
  endtask

  task automatic t_reset();
    chk(!token_o && !ack_o && !data_oe_o && busy_no && !full_o, "R1",
        {27'd0, token_o, ack_o, data_oe_o, busy_no, full_o}, 32'd2);
  endtask

  task automatic t_basic();
    wr(32'hA0); wr(32'hA1); wr(32'hA2);
    pulse_val();
    chk(!busy_no && !token_o, "R2", {busy_no, token_o}, 0);
    // strobe without token: ignored
    ds_i = 1; repeat (4) @(negedge clk_i);
    chk(!ack_o && !data_oe_o, "R3", {ack_o, data_oe_o}, 0);
    ds_i = 0; @(negedge clk_i);
    token_i = 1;
    read_word(32'hA0, "R5 w0");
    chk(!token_o && !busy_no, "R5 busy mid", {token_o, busy_no}, 0);
    read_word(32'hA1, "R5 w1");
    read_word(32'hA2, "R5 w2");
    chk(token_o && busy_no, "R6", {token_o, busy_no}, 2'b11);
    repeat (3) @(negedge clk_i);
    chk(token_o, "R10 hold", token_o, 1);
    token_i = 0;
  endtask

  task automatic t_empty();
    bit seen_ack = 0;
    pulse_val();
    chk(!token_o && !busy_no, "R10 clear", {token_o, busy_no}, 0);
    token_i = 1; ds_i = 1;
    @(negedge clk_i);
    seen_ack |= ack_o;
    chk(token_o && busy_no, "R7", {token_o, busy_no}, 2'b11);
    repeat (3) begin @(negedge clk_i); seen_ack |= ack_o; end
    chk(!seen_ack, "R7 no ack", seen_ack, 0);
    ds_i = 0; token_i = 0;
  endtask

  task automatic t_late();
    wr(32'hB0); wr(32'hB1);
    val_i = 1; wr_en_i = 1; wr_data_i = 32'hB2;
    @(negedge clk_i); val_i = 0; wr_en_i = 0;
    wr(32'hB3);
    token_i = 1;
    read_word(32'hB0, "R8 w0");
    pulse_val(); // during transfer
    read_word(32'hB1, "R9 w1");
    chk(token_o && busy_no, "R8 stop", {token_o, busy_no}, 2'b11);
    token_i = 0;
    pulse_val();
    token_i = 1;
    read_word(32'hB2, "R8 next0");
    read_word(32'hB3, "R8 next1");
    chk(token_o, "R6 end", token_o, 1);
    token_i = 0;
  endtask

  task automatic t_full();
    for (int i = 0; i < D; i++) wr(32'hC0 + i);
    chk(full_o, "R11 full", full_o, 1);
    wr(32'hDEAD);
    pulse_val();
    token_i = 1;
    for (int i = 0; i < D; i++) read_word(32'hC0 + i, "R11 data");
    chk(token_o && !full_o, "R11 drop", {token_o, full_o}, 2'b10);
    token_i = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1;
    @(negedge clk_i);
    t_reset();
    t_basic();
    t_empty();
    t_late();
    t_full();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule